// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port with Baud Divisor

The block is a full-duplex asynchronous serial port that sits on a 16-bit processor register bus. Each character on the line is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. That makes ten bit times per character. One shared oversampling tick paces both directions. The tick fires once every `divisor` clocks of the reference, which is nominally 30 MHz, so the baud rate is the reference divided by 16 times the divisor. A divisor of 49 gives about 38265 baud, and a divisor of 195 gives about 9615 baud.

Each direction has one holding register behind its shift register. Software can write the next character while the current one is still on the line. A received character also waits in the receive holding register while the next one is being shifted in. The status word reports the following:
- the transmit holding register is full;
- the receive holding register is full;
- a received character was overwritten (overflow);
- a stop bit was sampled low (framing error).

A read of the receive data register clears all three receive flags at the same time.

The register addresses are as follows:
- Address 0: a write loads the transmit holding register, and a read returns the received byte.
- Address 1: a read returns the status word.
- Address 2: a write sets the divisor, and a read returns it.
- Address 3: a read returns all ones.

The transmitter has four states:
- `TX_IDLE`: the line is high.
- `TX_START`: the line is low for one bit.
- `TX_DATA`: the eight bits are shifted out.
- `TX_STOP`: the line is high for one bit.

The transmitter moves from `TX_IDLE` to `TX_START` on a tick while the holding register is full, and the holding register is copied into the shifter at that point. It moves on to `TX_DATA` after 16 ticks, to `TX_STOP` after the eighth data bit, and back to `TX_IDLE` after 16 ticks of stop.

The receiver also has four states:
- `RX_IDLE`: it waits for a low line on a tick.
- `RX_START`: it re-checks the line on the 8th tick. If the line is still low it goes to `RX_DATA`; otherwise it returns to `RX_IDLE`.
- `RX_DATA`: it samples a bit every 16 ticks, and after eight bits goes to `RX_STOP`.
- `RX_STOP`: it samples the stop bit, delivers the byte and returns to `RX_IDLE`.

Top module: `sport_top`

## Requirements
- R1: After reset, `txd` is 1, the status read (address 1) returns 16'hFF0F, and the divisor read (address 2) returns 16'h0031 (49).
- R2: One bit on the line lasts exactly 16 × divisor clock cycles, for example 432 cycles for nine low bits at divisor 3. With a divisor of 2 or more, two ticks are never on adjacent cycles.
- R3: A transmitted character is a 0 start bit, then data bits 0 through 7, then a 1 stop bit.
- R4: A write to address 0 while the transmit holding register is empty stores the low byte and sets status bit 7. Once the shifter is idle, the holding register is moved into the shifter on the next tick, and bit 7 clears on that tick.
- R5: A write to address 0 while status bit 7 is 1 is ignored. Neither the held byte nor the characters sent on the line change.
- R6: A received character is available as {8'hFF, byte} at address 0, and status bit 6 is set.
- R7: A low pulse on `rxd` that ends before the mid-start check, the 8th tick, starts no character and sets no flag.
- R8: If the stop bit is sampled low, status bit 4 (framing error) is set, and the byte is still stored.
- R9: If a character completes while bit 6 is set, status bit 5 (overflow) is set, and the holding register takes the newer byte.
- R10: A read of address 0 clears status bits 6, 5 and 4 together.
- R11: The status word is {8'hFF, tx_full, rx_full, overflow, framing, 4'hF}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 30 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of address 0 clears the receive flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current `bus_addr` |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume the following about the inputs:
- Each bus access is a single-cycle strobe.
- The divisor is not rewritten in the middle of a character.
- A read of address 0 is not issued on the same cycle that the receiver delivers a byte, except where that case is checked explicitly.

The stimulus stays within these limits. It changes the divisor only while both lines are idle. It reads the receive register only after the bench's own stop bit has ended. It drives `rxd` in whole bit periods of 16 × divisor cycles. The one exception is a deliberately shortened low stop bit, which ends before the receiver could mistake it for a new start bit.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int BUS_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int CHAR_W  = 8;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_t;
endpackage

// File: rtl/sport_tick.sv
module sport_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - 1'b1;
        tick  = (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [CHAR_W-1:0] wdata,
    output logic              full,
    output logic [CHAR_W-1:0] hold,
    output logic              txd
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(CHAR_W);

    tx_state_t         state;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bitn;
    logic [CHAR_W-1:0] shreg;
    logic              last_tick;

    assign last_tick = (tcnt == CNT_W'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            hold  <= '0;
            full  <= 1'b0;
        end else begin
            if (wr && !full) begin
                hold <= wdata;
                full <= 1'b1;
            end
            if (tick) begin
                unique case (state)
                    TX_IDLE: if (full) begin
                        shreg <= hold;
                        full  <= 1'b0;
                        tcnt  <= '0;
                        state <= TX_START;
                    end
                    TX_START: if (last_tick) begin
                        tcnt  <= '0;
                        bitn  <= '0;
                        state <= TX_DATA;
                    end else tcnt <= tcnt + 1'b1;
                    TX_DATA: if (last_tick) begin
                        tcnt  <= '0;
                        shreg <= shreg >> 1;
                        if (bitn == BIT_W'(CHAR_W - 1)) state <= TX_STOP;
                        else bitn <= bitn + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                    TX_STOP: if (last_tick) begin
                        tcnt  <= '0;
                        state <= TX_IDLE;
                    end else tcnt <= tcnt + 1'b1;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              clr,
    output logic [CHAR_W-1:0] data,
    output logic              full,
    output logic              ovf,
    output logic              ferr,
    output logic              done
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(CHAR_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bitn;
    logic [CHAR_W-1:0] shreg;
    logic [1:0]        sync;
    logic              rx_s;
    logic              last_tick;

    assign rx_s      = sync[1];
    assign last_tick = (tcnt == CNT_W'(OVS - 1));
    assign done      = tick && (state == RX_STOP) && last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: if (!rx_s) begin
                    tcnt  <= '0;
                    state <= RX_START;
                end
                RX_START: if (tcnt == CNT_W'(OVS / 2 - 1)) begin
                    tcnt  <= '0;
                    bitn  <= '0;
                    state <= rx_s ? RX_IDLE : RX_DATA;
                end else tcnt <= tcnt + 1'b1;
                RX_DATA: if (last_tick) begin
                    tcnt  <= '0;
                    shreg <= {rx_s, shreg[CHAR_W-1:1]};
                    if (bitn == BIT_W'(CHAR_W - 1)) state <= RX_STOP;
                    else bitn <= bitn + 1'b1;
                end else tcnt <= tcnt + 1'b1;
                RX_STOP: if (last_tick) begin
                    tcnt  <= '0;
                    state <= RX_IDLE;
                end else tcnt <= tcnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovf  <= 1'b0;
            ferr <= 1'b0;
        end else begin
            if (clr) begin
                full <= 1'b0;
                ovf  <= 1'b0;
                ferr <= 1'b0;
            end
            if (done) begin
                data <= shreg;
                full <= 1'b1;
                if (full && !clr) ovf  <= 1'b1;
                if (!rx_s)        ferr <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int         DIV_W     = 8,
    parameter int         OVS       = 16,
    parameter logic [7:0] DIV_RESET = 8'd49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    localparam int PAD_W = BUS_W - CHAR_W;

    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              wr_tx, rd_rx;
    logic              tx_full;
    logic [CHAR_W-1:0] tx_hold;
    logic [CHAR_W-1:0] rx_data;
    logic              rx_full, rx_ovf, rx_ferr, rx_done;

    assign wr_tx = bus_wr && (bus_addr == A_DATA);
    assign rd_rx = bus_rd && (bus_addr == A_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             div_q <= DIV_W'(DIV_RESET);
        else if (bus_wr && bus_addr == A_DIV)   div_q <= bus_wdata[DIV_W-1:0];
    end

    sport_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    sport_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_tx),
        .wdata(bus_wdata[CHAR_W-1:0]), .full(tx_full), .hold(tx_hold),
        .txd(txd)
    );

    sport_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .clr(rd_rx),
        .data(rx_data), .full(rx_full), .ovf(rx_ovf), .ferr(rx_ferr),
        .done(rx_done)
    );

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = {{PAD_W{1'b1}}, rx_data};
            A_STAT:  bus_rdata = {{PAD_W{1'b1}}, tx_full, rx_full, rx_ovf, rx_ferr, 4'hF};
            A_DIV:   bus_rdata = BUS_W'(div_q);
            default: bus_rdata = '1;
        endcase
    end
endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [DIV_W-1:0] div_q,
    input logic             wr_tx,
    input logic             tx_full,
    input logic [7:0]       tx_hold,
    input logic             rd_rx,
    input logic             rx_done,
    input logic             rx_full,
    input logic             rx_ovf,
    input logic             rx_ferr
);
    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q >= 2) |=> !tick);

    // R4
    hold_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_full) |-> $past(tick));

    // R5
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> $stable(tx_hold));

    // R9
    overflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(rx_full));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_done) |=> (!rx_full && !rx_ovf && !rx_ferr));

    // R6
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_full);
endmodule

bind sport_top sport_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_q(div_q),
    .wr_tx(wr_tx), .tx_full(tx_full), .tx_hold(tx_hold),
    .rd_rx(rd_rx), .rx_done(rx_done), .rx_full(rx_full),
    .rx_ovf(rx_ovf), .rx_ferr(rx_ferr)
);

// File: tb/sport_top_tb.sv
module sport_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sport_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input int div, input bit good_stop);
        int bt;
        bt = 16 * div;
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bt) @(negedge clk);
        end
        if (good_stop) begin
            rxd = 1'b1;
            repeat (bt) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (12 * div) @(negedge clk);
            rxd = 1'b1;
            repeat (bt) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic grab_tx(input int div, output logic [7:0] b, output logic stopb);
        while (txd !== 1'b0) @(negedge clk);
        repeat (8 * div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * div) @(negedge clk);
            b[i] = txd;
        end
        repeat (16 * div) @(negedge clk);
        stopb = txd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  b, b2;
        logic        sb, sb2;
        int          lowcnt, noise;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 txd idle", {15'd0, txd}, 16'd1);
        bus_read(2'd1, r); check("R1 status", r, 16'hFF0F);
        bus_read(2'd2, r); check("R1 divisor", r, 16'h0031);

        // R6 R10 R11 exhaustive receive sweep at divisor 1
        bus_write(2'd2, 16'd1);
        for (int v = 0; v < 256; v++) begin
            send_rx(v[7:0], 1, 1'b1);
            bus_read(2'd1, r); check("R11 R6 status full", r, 16'hFF4F);
            bus_read(2'd0, r); check("R6 data", r, {8'hFF, v[7:0]});
            bus_read(2'd1, r); check("R10 cleared", r, 16'hFF0F);
        end

        // R8 framing error, byte still stored
        send_rx(8'h5A, 1, 1'b0);
        bus_read(2'd1, r); check("R8 framing", r, 16'hFF5F);
        bus_read(2'd0, r); check("R8 data kept", r, 16'hFF5A);
        bus_read(2'd1, r); check("R10 framing cleared", r, 16'hFF0F);

        // R9 overflow keeps newer byte
        send_rx(8'h11, 1, 1'b1);
        send_rx(8'hE7, 1, 1'b1);
        bus_read(2'd1, r); check("R9 overflow", r, 16'hFF6F);
        bus_read(2'd0, r); check("R9 newer byte", r, 16'hFFE7);
        bus_read(2'd1, r); check("R10 overflow cleared", r, 16'hFF0F);

        // R7 short low glitch ignored
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        bus_read(2'd1, r); check("R7 glitch", r, 16'hFF0F);

        // R2 receive at divisor 3
        bus_write(2'd2, 16'd3);
        send_rx(8'hA5, 3, 1'b1);
        bus_read(2'd0, r); check("R2 R6 rx div3", r, 16'hFFA5);
        send_rx(8'h3C, 3, 1'b1);
        bus_read(2'd0, r); check("R2 R6 rx div3 b", r, 16'hFF3C);

        // R3 transmit sweep at divisor 1
        bus_write(2'd2, 16'd1);
        for (int v = 0; v < 256; v += 17) begin
            fork
                grab_tx(1, b, sb);
                bus_write(2'd0, 16'(v));
            join
            check("R3 tx byte", {8'h00, b}, {8'h00, v[7:0]});
            check("R3 tx stop", {15'd0, sb}, 16'd1);
            repeat (20) @(negedge clk);
        end

        // R4 R5 double buffering and ignored write
        fork
            begin
                grab_tx(1, b, sb);
                grab_tx(1, b2, sb2);
            end
            begin
                bus_write(2'd0, 16'h00C3);
                repeat (3) @(negedge clk);
                bus_read(2'd1, r); check("R4 moved to shifter", r, 16'hFF0F);
                bus_write(2'd0, 16'h0096);
                bus_read(2'd1, r); check("R4 holding full", r, 16'hFF8F);
                bus_write(2'd0, 16'h0077);
            end
        join
        check("R4 first char", {8'h00, b}, 16'h00C3);
        check("R4 second char", {8'h00, b2}, 16'h0096);
        noise = 0;
        repeat (400) begin
            @(negedge clk);
            if (txd !== 1'b1) noise++;
        end
        check("R5 no third char", 16'(noise), 16'd0);
        bus_read(2'd1, r); check("R5 status idle", r, 16'hFF0F);

        // R2 bit length at divisor 3
        bus_write(2'd2, 16'd3);
        fork
            begin
                while (txd !== 1'b0) @(negedge clk);
                lowcnt = 0;
                while (txd === 1'b0) begin
                    lowcnt++;
                    @(negedge clk);
                end
            end
            bus_write(2'd0, 16'h0000);
        join
        check("R2 nine low bits", 16'(lowcnt), 16'd432);
        repeat (60) @(negedge clk);
        fork
            grab_tx(3, b, sb);
            bus_write(2'd0, 16'h00B2);
        join
        check("R2 R3 tx div3", {8'h00, b}, 16'h00B2);
        check("R3 tx div3 stop", {15'd0, sb}, 16'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule